// File: doc/BRIEF.md
# Link-Layer Transmit Priority Arbiter

This block decides which of six link-layer packet sources may use the transmit link next. The six sources are flow-control initialization, ACK/NAK, flow-control update, power management, replayed transaction packets and new transaction packets. Each source presents a level request. The arbiter answers with a one-hot grant that stays asserted until the output side signals that the packet has been fully sent.

ACK/NAK and flow-control update requests each carry an urgency flag. An urgent request competes at a level above transaction traffic. A non-urgent one competes at a level below it. This gives a fixed eight-level order.

A non-urgent ACK/NAK or update request that waits too long is promoted to its urgent level. The wait limit is a programmable cycle count, so such requests cannot starve behind a steady stream of transactions.

Top module: `lnk_tx_prio_arb`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `gnt` is all zeros and `gnt_lvl` is 0.
- R2: `gnt` never has more than one bit set. Bit positions: 0 = flow-control init, 1 = ACK/NAK, 2 = flow-control update, 3 = power management, 4 = replay, 5 = new transaction.
- R3: When `gnt` is zero and at least one request is high at a rising edge, that edge sets the grant bit of the winning source.
- R4: A grant stays unchanged until `pkt_done` is high at an edge. That edge clears `gnt`, so there is at least one idle cycle between two packets.
- R5: A flow-control init request always wins.
- R6: Below flow-control init, the order is urgent ACK/NAK, then urgent flow-control update, then power management.
- R7: Below power management, the order is replay, then new transaction, then non-urgent flow-control update, then non-urgent ACK/NAK (lowest).
- R8: An ACK/NAK or update request that has been high and ungranted for at least `promote_limit` consecutive edges competes at its urgent level. A limit of 0 promotes it at once.
- R9: With no request pending, `gnt` stays zero. A `pkt_done` pulse while idle has no effect.
- R10: While a grant is held, `gnt_lvl` gives the winning level from 0 (highest) to 7 (lowest), in the order of R5 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_fcinit | input | 1 | Flow-control init packet pending |
| req_acknak | input | 1 | ACK/NAK packet pending |
| acknak_urgent | input | 1 | ACK/NAK request is urgent |
| req_fcupd | input | 1 | Flow-control update pending |
| fcupd_urgent | input | 1 | Flow-control update is urgent |
| req_pm | input | 1 | Power-management packet pending |
| req_replay | input | 1 | Replayed transaction packet pending |
| req_tlp | input | 1 | New transaction packet pending |
| promote_limit | input | AGE_W | Wait cycles before a non-urgent request is promoted |
| pkt_done | input | 1 | Output has finished sending the granted packet |
| gnt | output | 6 | One-hot grant per source |
| gnt_lvl | output | 3 | Priority level of the current grant |

## Verification
On every cycle, the embedded assertions check the one-hot grant, that a grant holds until `pkt_done`, the release edge, the idle behaviour with no requests, the grant issue edge, the win by flow-control init, and agreement between the granted bit and the reported level. The full eight-level order cannot be expressed as one property. The bench's cycle-by-cycle model shows it under dense and sparse random traffic with random urgency. The bench also shows age promotion with a limit of 0, a short limit and a long one. A directed pair shows that the same waiting ACK/NAK either beats or loses to new transactions depending on the limit.

// File: rtl/lnk_tx_prio_arb.sv
module lnk_tx_prio_arb #(
  parameter int AGE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_fcinit,
  input  logic             req_acknak,
  input  logic             acknak_urgent,
  input  logic             req_fcupd,
  input  logic             fcupd_urgent,
  input  logic             req_pm,
  input  logic             req_replay,
  input  logic             req_tlp,
  input  logic [AGE_W-1:0] promote_limit,
  input  logic             pkt_done,
  output logic [5:0]       gnt,
  output logic [2:0]       gnt_lvl
);
  localparam int NSRC = 6;
  localparam int NLVL = 8;
  localparam int LW   = $clog2(NLVL);
  localparam int SW   = $clog2(NSRC);
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  logic [AGE_W-1:0] age_ak, age_fc;
  logic             ak_hi, fc_hi;
  logic [NLVL-1:0]  lvl_req;
  logic [LW-1:0]    win_lvl;
  logic             win_any;
  logic [NSRC-1:0]  win_oh;
  logic             idle;

  function automatic logic [SW-1:0] lvl2src(input logic [LW-1:0] l);
    case (l)
      3'd6:    lvl2src = SW'(2);
      3'd7:    lvl2src = SW'(1);
      default: lvl2src = SW'(l);
    endcase
  endfunction

  assign idle  = (gnt == '0);
  assign ak_hi = acknak_urgent | (age_ak >= promote_limit);
  assign fc_hi = fcupd_urgent  | (age_fc >= promote_limit);

  assign lvl_req = {req_acknak & ~ak_hi, req_fcupd & ~fc_hi, req_tlp, req_replay,
                    req_pm, req_fcupd & fc_hi, req_acknak & ak_hi, req_fcinit};

  always_comb begin
    win_lvl = '0;
    win_any = 1'b0;
    for (int i = NLVL - 1; i >= 0; i--) begin
      if (lvl_req[i]) begin
        win_lvl = LW'(i);
        win_any = 1'b1;
      end
    end
  end

  assign win_oh = NSRC'(1) << lvl2src(win_lvl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt     <= '0;
      gnt_lvl <= '0;
    end else if (idle) begin
      if (win_any) begin
        gnt     <= win_oh;
        gnt_lvl <= win_lvl;
      end
    end else if (pkt_done) begin
      gnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !req_acknak || gnt[1]) age_ak <= '0;
    else if (age_ak != AGE_MAX)          age_ak <= age_ak + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !req_fcupd || gnt[2]) age_fc <= '0;
    else if (age_fc != AGE_MAX)         age_fc <= age_fc + 1'b1;
  end

  logic any_req;
  assign any_req = req_fcinit | req_acknak | req_fcupd | req_pm | req_replay | req_tlp;

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && any_req) |=> (gnt != '0));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !pkt_done) |=> ($stable(gnt) && $stable(gnt_lvl)));
  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && pkt_done) |=> (gnt == '0));
  assert_fcinit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && req_fcinit) |=> (gnt == 6'b000001 && gnt_lvl == 3'd0));
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !any_req) |=> (gnt == '0));
  assert_lvl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |-> (gnt == (NSRC'(1) << lvl2src(gnt_lvl))));
endmodule

// File: tb/lnk_tx_prio_arb_tb.sv
module lnk_tx_prio_arb_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req_fcinit, req_acknak, acknak_urgent, req_fcupd, fcupd_urgent;
  logic req_pm, req_replay, req_tlp, pkt_done;
  logic [7:0] promote_limit;
  logic [5:0] gnt;
  logic [2:0] gnt_lvl;

  int total = 0, bad = 0;
  int m_src = -1, m_lvl = 0, m_age_a = 0, m_age_f = 0;
  string phase_tag = "";

  lnk_tx_prio_arb #(.AGE_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_fcinit(req_fcinit), .req_acknak(req_acknak),
    .acknak_urgent(acknak_urgent), .req_fcupd(req_fcupd), .fcupd_urgent(fcupd_urgent),
    .req_pm(req_pm), .req_replay(req_replay), .req_tlp(req_tlp),
    .promote_limit(promote_limit), .pkt_done(pkt_done), .gnt(gnt), .gnt_lvl(gnt_lvl));

  function automatic int lvl_to_src(int l);
    if (l == 6) return 2;
    if (l == 7) return 1;
    return l;
  endfunction

  always @(posedge clk) begin : model
    int old, best;
    bit ah, fh;
    if (!rst_n) begin
      m_src = -1; m_lvl = 0; m_age_a = 0; m_age_f = 0;
    end else begin
      old  = m_src;
      ah   = acknak_urgent || (m_age_a >= int'(promote_limit));
      fh   = fcupd_urgent  || (m_age_f >= int'(promote_limit));
      best = -1;
      if (old < 0) begin
        if      (req_fcinit)        best = 0;
        else if (req_acknak && ah)  best = 1;
        else if (req_fcupd && fh)   best = 2;
        else if (req_pm)            best = 3;
        else if (req_replay)        best = 4;
        else if (req_tlp)           best = 5;
        else if (req_fcupd)         best = 6;
        else if (req_acknak)        best = 7;
        if (best >= 0) begin
          m_src = lvl_to_src(best);
          m_lvl = best;
        end
      end else if (pkt_done) begin
        m_src = -1;
      end
      m_age_a = (!req_acknak || old == 1) ? 0 : (m_age_a < 255 ? m_age_a + 1 : 255);
      m_age_f = (!req_fcupd  || old == 2) ? 0 : (m_age_f < 255 ? m_age_f + 1 : 255);
    end
  end

  task automatic compare();
    logic [5:0] exp;
    string tag;
    exp = (m_src < 0) ? 6'b0 : 6'(1 << m_src);
    if (phase_tag != "") tag = phase_tag;
    else if (m_src < 0)  tag = "R9";
    else if (m_lvl == 0) tag = "R5";
    else if (m_lvl <= 3) tag = "R6";
    else                 tag = "R7";
    total++;
    if (gnt !== exp || (m_src >= 0 && gnt_lvl !== 3'(m_lvl))) begin
      bad++;
      $display("FAIL %s (R3 R4 R10) gnt=%b lvl=%0d expected gnt=%b lvl=%0d",
               tag, gnt, gnt_lvl, exp, m_lvl);
    end
    total++;
    if ($countones(gnt) > 1) begin
      bad++;
      $display("FAIL R2 gnt=%b expected at most one bit", gnt);
    end
  endtask

  task automatic clear_in();
    {req_fcinit, req_acknak, acknak_urgent, req_fcupd, fcupd_urgent} = '0;
    {req_pm, req_replay, req_tlp, pkt_done} = '0;
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic rand_phase(int n, int dens, int done_pct, int lim);
    promote_limit = 8'(lim);
    for (int i = 0; i < n; i++) begin
      step();
      req_fcinit    = ($urandom_range(99) < dens / 4);
      req_acknak    = ($urandom_range(99) < dens);
      acknak_urgent = $urandom_range(1);
      req_fcupd     = ($urandom_range(99) < dens);
      fcupd_urgent  = $urandom_range(1);
      req_pm        = ($urandom_range(99) < dens / 2);
      req_replay    = ($urandom_range(99) < dens);
      req_tlp       = ($urandom_range(99) < dens);
      pkt_done      = ($urandom_range(99) < done_pct);
    end
  endtask

  task automatic aging_case(int lim, logic [5:0] exp_g, int exp_l, string tag);
    phase_tag = tag;
    clear_in();
    promote_limit = 8'(lim);
    step(); step();
    req_replay = 1'b1;
    step();
    req_replay = 1'b0; req_acknak = 1'b1; acknak_urgent = 1'b0; req_tlp = 1'b1;
    for (int i = 0; i < 8; i++) step();
    pkt_done = 1'b1;
    step();
    pkt_done = 1'b0;
    step();
    total++;
    if (gnt !== exp_g || gnt_lvl !== 3'(exp_l)) begin
      bad++;
      $display("FAIL %s gnt=%b lvl=%0d expected gnt=%b lvl=%0d", tag, gnt, gnt_lvl, exp_g, exp_l);
    end
    clear_in();
    pkt_done = 1'b1;
    step();
    pkt_done = 1'b0;
    step();
    phase_tag = "";
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_in();
    promote_limit = 8'd6;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    total++;
    if (gnt !== 6'b0 || gnt_lvl !== 3'd0) begin
      bad++;
      $display("FAIL R1 gnt=%b lvl=%0d expected gnt=000000 lvl=0", gnt, gnt_lvl);
    end
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (gnt !== 6'b0 || gnt_lvl !== 3'd0) begin
      bad++;
      $display("FAIL R1 gnt=%b lvl=%0d expected gnt=000000 lvl=0", gnt, gnt_lvl);
    end
    rand_phase(3000, 50, 30, 6);
    rand_phase(3000, 12, 50, 20);
    rand_phase(1500, 40, 35, 0);
    clear_in();
    phase_tag = "R9";
    for (int i = 0; i < 10; i++) begin
      pkt_done = i[0];
      step();
    end
    phase_tag = "";
    aging_case(4,   6'b000010, 1, "R8");
    aging_case(200, 6'b100000, 5, "R7");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule